// File: doc/BRIEF.md
# PCIe Error Header Logging Sequencer

This block sits on the application side of a PCI Express endpoint and turns an error report from user logic into the signalling the transaction-layer core expects. User logic offers one report at a time on a valid/ready channel: a 128-bit TLP header, a flag saying whether the rejected request was posted or non-posted, and a flag saying whether the header should be logged. When logging is requested, the block uploads the header as four 32-bit writes over a simple local management register port. Only after the last write is acknowledged does it pulse the 7-bit error vector. In that pulse the unsupported-request bit and the log-header bit are high in the same cycle.

For a non-posted request the block also asks the completion generator for an unsupported-request completion. It holds that request until the generator accepts it, and only then fires the error pulse. A separate counter tracks locally originated requests that are still waiting for a completion and drives a completion-pending flag.

Back-pressure rule: `rep_ready` is high only while the block is idle. A report is taken on a cycle where `rep_valid` and `rep_ready` are both high. A report offered while the block is busy stays on the inputs until the block returns to idle, and it is not lost.

Top module: `pcie_errlog_seq`

## Requirements
- R1: After reset `rep_ready` is 1, and `mgmt_wr`, `cpl_req_valid`, `err_vec` and `cpl_pending` are 0. `rep_ready` is 1 exactly when no report is in progress. It is 0 from the cycle after a report is accepted until that report's error pulse has ended.
- R2: With logging requested, the block makes four management writes in this order: header bits [127:96] to address 12'h81C, [95:64] to 12'h820, [63:32] to 12'h824 and [31:0] to 12'h828.
- R3: Each write holds `mgmt_wr`, `mgmt_addr` and `mgmt_wdata` stable until a cycle in which `mgmt_ack` is 1. The next write appears in the cycle after that acknowledge, not earlier.
- R4: `err_vec` is nonzero for exactly one cycle per accepted report and is zero in every other cycle. That cycle follows the last write acknowledge, and for a non-posted report it also follows the completion acceptance.
- R5: Encoding of `err_vec`: bit 4 means unsupported request on a posted TLP (`rep_nonposted`=0), and bit 5 means unsupported request on a non-posted TLP (`rep_nonposted`=1). With logging requested, bit 6 is 1 in the same cycle. Bits 3:0 are always 0.
- R6: With `rep_log`=0 no management write takes place and bit 6 stays 0. Only the error bit is pulsed.
- R7: For a non-posted report, `cpl_req_valid` rises after the writes and stays 1 until a cycle with `cpl_req_ready`=1. The error pulse comes in the next cycle. A posted report never raises `cpl_req_valid`.
- R8: `cpl_pending` is 1 exactly while the count of outstanding requests is nonzero. `req_issue` adds one to the count and `cpl_rcvd` removes one. Both together leave the count unchanged, and a receipt at a count of zero has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rep_valid | input | 1 | Error report offered |
| rep_ready | output | 1 | Block idle, report can be taken |
| rep_nonposted | input | 1 | 1: non-posted request, 0: posted |
| rep_log | input | 1 | Request header logging |
| rep_hdr | input | 128 | TLP header to log |
| mgmt_wr | output | 1 | Management write strobe |
| mgmt_addr | output | 12 | Management write address |
| mgmt_wdata | output | 32 | Management write data |
| mgmt_ack | input | 1 | One-cycle write acknowledge |
| cpl_req_valid | output | 1 | Request for an unsupported-request completion |
| cpl_req_ready | input | 1 | Completion generator accepts the request |
| err_vec | output | 7 | Error report vector, one-cycle pulse |
| req_issue | input | 1 | A local request was issued |
| cpl_rcvd | input | 1 | A completion for a local request arrived |
| cpl_pending | output | 1 | At least one local request is outstanding |

## Verification
A sequencer stuck in a wrong state shows at once at the ports. `rep_ready` stays low or goes high early, writes repeat or skip an address, or `err_vec` fires before the last acknowledge, all within the cycle after the acknowledge or handshake that should have moved it. A wrong word index shows as an address and data pair that does not match the header slice on the very write where it occurs. A corrupted outstanding count shows on `cpl_pending` in the cycle after the issue or receipt that exposes it, in particular after a receipt at zero followed by one issue and one receipt.

// File: rtl/errlog_pkg.sv
package errlog_pkg;
  localparam int ERR_W        = 7;
  localparam int BIT_UR_POST  = 4;
  localparam int BIT_UR_NPOST = 5;
  localparam int BIT_LOG      = 6;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_CPL   = 2'd2,
    ST_PULSE = 2'd3
  } seq_state_t;

  typedef struct packed {
    logic nonposted;
    logic log_en;
  } rep_attr_t;
endpackage

// File: rtl/errlog_hdr_slicer.sv
module errlog_hdr_slicer #(
  parameter int HDR_W  = 128,
  parameter int WORD_W = 32,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h81C,
  parameter int STRIDE = 4,
  localparam int NWORDS = HDR_W / WORD_W,
  localparam int IDX_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic [HDR_W-1:0]  hdr,
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] addr,
  output logic [WORD_W-1:0] word
);
  // Word 0 is the most significant slice; it goes to the lowest address.
  logic [WORD_W-1:0] slices [NWORDS];
  logic [ADDR_W-1:0] addrs  [NWORDS];

  for (genvar g = 0; g < NWORDS; g++) begin : g_slice
    assign slices[g] = hdr[HDR_W-1-g*WORD_W -: WORD_W];
    assign addrs[g]  = BASE_ADDR + ADDR_W'(g * STRIDE);
  end

  always_comb begin
    addr = '0;
    word = '0;
    for (int i = 0; i < NWORDS; i++) begin
      if (idx == IDX_W'(i)) begin
        addr = addrs[i];
        word = slices[i];
      end
    end
  end
endmodule

// File: rtl/errlog_seq_fsm.sv
module errlog_seq_fsm
  import errlog_pkg::*;
#(
  parameter int NWORDS = 4,
  localparam int IDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rep_valid,
  input  logic             rep_nonposted,
  input  logic             rep_log,
  output logic             rep_ready,
  output logic             capture,
  output logic [IDX_W-1:0] word_idx,
  output logic             mgmt_wr,
  input  logic             mgmt_ack,
  output logic             cpl_req_valid,
  input  logic             cpl_req_ready,
  output logic [ERR_W-1:0] err_vec
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NWORDS - 1);

  seq_state_t       state_q, state_d;
  rep_attr_t        attr_q;
  logic [IDX_W-1:0] idx_q, idx_d;

  assign rep_ready     = (state_q == ST_IDLE);
  assign capture       = rep_ready && rep_valid;
  assign mgmt_wr       = (state_q == ST_WRITE);
  assign cpl_req_valid = (state_q == ST_CPL);
  assign word_idx      = idx_q;

  // State entered once the header upload is done (or skipped).
  function automatic seq_state_t after_upload(input logic np);
    return np ? ST_CPL : ST_PULSE;
  endfunction

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    unique case (state_q)
      ST_IDLE: begin
        if (rep_valid) begin
          idx_d   = '0;
          state_d = rep_log ? ST_WRITE : after_upload(rep_nonposted);
        end
      end
      ST_WRITE: begin
        if (mgmt_ack) begin
          if (idx_q == LAST_IDX) state_d = after_upload(attr_q.nonposted);
          else                   idx_d   = idx_q + 1'b1;
        end
      end
      ST_CPL:   if (cpl_req_ready) state_d = ST_PULSE;
      ST_PULSE: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      attr_q  <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      if (capture) begin
        attr_q.nonposted <= rep_nonposted;
        attr_q.log_en    <= rep_log;
      end
    end
  end

  always_comb begin
    err_vec = '0;
    if (state_q == ST_PULSE) begin
      if (attr_q.nonposted) err_vec[BIT_UR_NPOST] = 1'b1;
      else                  err_vec[BIT_UR_POST]  = 1'b1;
      err_vec[BIT_LOG] = attr_q.log_en;
    end
  end
endmodule

// File: rtl/errlog_pend_ctr.sv
module errlog_pend_ctr #(
  parameter int CNT_W = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic nonzero
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (inc && !dec) begin
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end else if (dec && !inc) begin
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign nonzero = (cnt_q != '0);
endmodule

// File: rtl/pcie_errlog_seq.sv
module pcie_errlog_seq
  import errlog_pkg::*;
#(
  parameter int HDR_W  = 128,
  parameter int WORD_W = 32,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h81C,
  parameter int STRIDE = 4,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rep_valid,
  output logic              rep_ready,
  input  logic              rep_nonposted,
  input  logic              rep_log,
  input  logic [HDR_W-1:0]  rep_hdr,
  output logic              mgmt_wr,
  output logic [ADDR_W-1:0] mgmt_addr,
  output logic [WORD_W-1:0] mgmt_wdata,
  input  logic              mgmt_ack,
  output logic              cpl_req_valid,
  input  logic              cpl_req_ready,
  output logic [ERR_W-1:0]  err_vec,
  input  logic              req_issue,
  input  logic              cpl_rcvd,
  output logic              cpl_pending
);
  localparam int NWORDS = HDR_W / WORD_W;
  localparam int IDX_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1;

  logic             capture;
  logic [IDX_W-1:0] word_idx;
  logic [HDR_W-1:0] hdr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       hdr_q <= '0;
    else if (capture) hdr_q <= rep_hdr;
  end

  errlog_seq_fsm #(.NWORDS(NWORDS)) fsm_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .rep_valid     (rep_valid),
    .rep_nonposted (rep_nonposted),
    .rep_log       (rep_log),
    .rep_ready     (rep_ready),
    .capture       (capture),
    .word_idx      (word_idx),
    .mgmt_wr       (mgmt_wr),
    .mgmt_ack      (mgmt_ack),
    .cpl_req_valid (cpl_req_valid),
    .cpl_req_ready (cpl_req_ready),
    .err_vec       (err_vec)
  );

  errlog_hdr_slicer #(
    .HDR_W(HDR_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W),
    .BASE_ADDR(BASE_ADDR), .STRIDE(STRIDE)
  ) slicer_i (
    .hdr  (hdr_q),
    .idx  (word_idx),
    .addr (mgmt_addr),
    .word (mgmt_wdata)
  );

  errlog_pend_ctr #(.CNT_W(CNT_W)) pend_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc     (req_issue),
    .dec     (cpl_rcvd),
    .nonzero (cpl_pending)
  );
endmodule

// File: rtl/errlog_seq_chk.sv
module errlog_seq_chk #(
  parameter int HDR_W  = 128,
  parameter int WORD_W = 32,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rep_valid,
  input logic              rep_ready,
  input logic              rep_nonposted,
  input logic              rep_log,
  input logic [HDR_W-1:0]  rep_hdr,
  input logic              mgmt_wr,
  input logic [ADDR_W-1:0] mgmt_addr,
  input logic [WORD_W-1:0] mgmt_wdata,
  input logic              mgmt_ack,
  input logic              cpl_req_valid,
  input logic              cpl_req_ready,
  input logic [6:0]        err_vec,
  input logic              req_issue,
  input logic              cpl_rcvd,
  input logic              cpl_pending
);
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_wr || cpl_req_valid || err_vec != '0) |-> !rep_ready); // R1
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_wr && !mgmt_ack) |=> (mgmt_wr && $stable(mgmt_addr) && $stable(mgmt_wdata))); // R3
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (err_vec != '0) |=> (err_vec == '0)); // R4
  AST_ERR_QUIET_IN_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (err_vec != '0) |-> (!mgmt_wr && !cpl_req_valid)); // R4
  AST_ERR_ENCODING: assert property (@(posedge clk) disable iff (!rst_n)
    (err_vec[3:0] == 4'd0) && $onehot0(err_vec[5:4])); // R5
  AST_LOG_WITH_UR: assert property (@(posedge clk) disable iff (!rst_n)
    err_vec[6] |-> (err_vec[5] || err_vec[4])); // R5
  AST_CPL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_req_valid && !cpl_req_ready) |=> cpl_req_valid); // R7
  AST_PEND_ZERO_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpl_pending && cpl_rcvd && !req_issue) |=> !cpl_pending); // R8
  AST_PEND_ON_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_issue && !cpl_rcvd) |=> cpl_pending); // R8
endmodule

bind pcie_errlog_seq errlog_seq_chk #(
  .HDR_W(HDR_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W)
) chk_i (.*);

// File: tb/pcie_errlog_seq_tb_top.sv
`timescale 1ns/1ps
module pcie_errlog_seq_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         rep_valid = 1'b0, rep_nonposted = 1'b0, rep_log = 1'b0;
  logic         rep_ready;
  logic [127:0] rep_hdr = '0;
  logic         mgmt_wr, mgmt_ack = 1'b0;
  logic [11:0]  mgmt_addr;
  logic [31:0]  mgmt_wdata;
  logic         cpl_req_valid, cpl_req_ready = 1'b0;
  logic [6:0]   err_vec;
  logic         req_issue = 1'b0, cpl_rcvd = 1'b0, cpl_pending;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  pcie_errlog_seq dut_i (.*);

  task automatic check(input bit ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  // One report: drive it, answer writes after ack_dly cycles and the
  // completion request after cpl_dly cycles, then check the pulse.
  task automatic run_report(input bit np, input bit lg, input int ack_dly,
                            input int cpl_dly, input logic [127:0] hdr);
    logic [6:0] exp_vec;
    @(negedge clk);
    check(rep_ready === 1'b1, "R1 ready in idle", 128'(rep_ready), 128'd1);
    rep_valid = 1'b1; rep_nonposted = np; rep_log = lg; rep_hdr = hdr;
    @(posedge clk);
    @(negedge clk);
    rep_valid = 1'b0; rep_hdr = ~hdr;
    check(rep_ready === 1'b0, "R1 busy after accept", 128'(rep_ready), 128'd0);
    if (lg) begin
      for (int w = 0; w < 4; w++) begin
        logic [11:0] ea;
        logic [31:0] ed;
        ea = 12'h81C + 12'(4 * w);
        ed = hdr[127 - 32*w -: 32];
        check(mgmt_wr === 1'b1 && mgmt_addr === ea && mgmt_wdata === ed,
              "R2 write order", {mgmt_wr, mgmt_addr, mgmt_wdata},
              {1'b1, ea, ed});
        for (int d = 0; d < ack_dly; d++) begin
          @(negedge clk);
          check(mgmt_wr === 1'b1 && mgmt_addr === ea && mgmt_wdata === ed
                && err_vec === 7'd0 && rep_ready === 1'b0,
                "R3 write held", {mgmt_wr, mgmt_addr, mgmt_wdata},
                {1'b1, ea, ed});
        end
        mgmt_ack = 1'b1;
        @(posedge clk);
        @(negedge clk);
        mgmt_ack = 1'b0;
      end
    end else begin
      check(mgmt_wr === 1'b0, "R6 no write", 128'(mgmt_wr), 128'd0);
    end
    if (np) begin
      check(cpl_req_valid === 1'b1 && mgmt_wr === 1'b0, "R7 cpl request",
            128'(cpl_req_valid), 128'd1);
      for (int d = 0; d < cpl_dly; d++) begin
        @(negedge clk);
        check(cpl_req_valid === 1'b1 && err_vec === 7'd0, "R7 cpl held",
              {cpl_req_valid, err_vec}, {1'b1, 7'd0});
      end
      cpl_req_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      cpl_req_ready = 1'b0;
    end else begin
      check(cpl_req_valid === 1'b0, "R7 posted no cpl", 128'(cpl_req_valid), 128'd0);
    end
    exp_vec = 7'd0;
    exp_vec[np ? 5 : 4] = 1'b1;
    exp_vec[6] = lg;
    check(err_vec === exp_vec, lg ? "R5 pulse with log" : "R6 pulse no log",
          128'(err_vec), 128'(exp_vec));
    check(mgmt_wr === 1'b0, "R4 no write at pulse", 128'(mgmt_wr), 128'd0);
    @(negedge clk);
    check(err_vec === 7'd0 && rep_ready === 1'b1, "R4 single pulse",
          {err_vec, rep_ready}, {7'd0, 1'b1});
  endtask

  task automatic pend_step(input bit iss, input bit rcv, inout int model);
    @(negedge clk);
    req_issue = iss; cpl_rcvd = rcv;
    @(posedge clk);
    @(negedge clk);
    req_issue = 1'b0; cpl_rcvd = 1'b0;
    if (iss && !rcv) model++;
    else if (rcv && !iss && model > 0) model--;
    check(cpl_pending === (model != 0), "R8 pending", 128'(cpl_pending),
          128'(model != 0));
  endtask

  initial begin
    int model;
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(rep_ready === 1'b1 && mgmt_wr === 1'b0 && cpl_req_valid === 1'b0
          && err_vec === 7'd0 && cpl_pending === 1'b0, "R1 reset state",
          {rep_ready, mgmt_wr, cpl_req_valid, err_vec, cpl_pending},
          {1'b1, 10'd0});
    rst_n = 1'b1;
    n = 0;
    for (int np = 0; np < 2; np++)
      for (int lg = 0; lg < 2; lg++)
        for (int ad = 0; ad < 3; ad++)
          for (int cd = 0; cd < 3; cd++) begin
            logic [127:0] h;
            n++;
            for (int k = 0; k < 4; k++)
              h[127 - 32*k -: 32] = 32'h1357_9BDF * 32'(n) + 32'h0101_0101 * 32'(k + 1);
            run_report(np[0], lg[0], ad, cd, h);
          end
    // Back-pressure: a report held valid while busy is taken afterwards.
    @(negedge clk);
    rep_valid = 1'b1; rep_nonposted = 1'b0; rep_log = 1'b0; rep_hdr = '0;
    @(posedge clk);
    @(negedge clk);
    check(rep_ready === 1'b0 && err_vec === 7'h10, "R1 first pulse",
          128'(err_vec), 128'h10);
    @(negedge clk);
    check(rep_ready === 1'b1 && err_vec === 7'd0, "R1 idle between",
          128'(err_vec), 128'd0);
    @(posedge clk);
    @(negedge clk);
    rep_valid = 1'b0;
    check(err_vec === 7'h10, "R1 held report taken", 128'(err_vec), 128'h10);
    @(negedge clk);
    check(err_vec === 7'd0, "R4 quiet after", 128'(err_vec), 128'd0);
    // Outstanding counter
    model = 0;
    pend_step(1'b0, 1'b1, model);
    for (int i = 0; i < 3; i++) pend_step(1'b1, 1'b0, model);
    pend_step(1'b1, 1'b1, model);
    for (int i = 0; i < 5; i++) pend_step(1'b0, 1'b1, model);
    pend_step(1'b1, 1'b0, model);
    pend_step(1'b0, 1'b1, model);
    finish_run();
  end
endmodule